// File: doc/BRIEF.md
# Packed Float32 Bound-Select Lane Array

This block takes pairs of single-precision values from two 512-bit sources and computes one result per 32-bit lane. Each lane picks one value of its pair by a signed or magnitude minimum or maximum. It then rewrites the sign bit as the control asks. NaN and denormal operands follow fixed rules, and two exception flags report them. A typical use is clamping: a min-magnitude select against a bound, with the sign taken from the first operand, limits a value to plus or minus that bound.

Around the sixteen lane units sits the packed-vector handling. A length code picks 4, 8 or 16 active lanes. A per-lane write mask either keeps the previous destination lane or writes zero in lanes it disables. A broadcast mode feeds lane 0 of source B to every lane. Everything above the active length is zero. The result, the flags and a length-error indication appear one cycle after the input strobe.

Top module: `fbound_vec_unit`

## Requirements
- R1: Lane j occupies bits 32j+31..32j. `vlen` code 0, 1 and 2 selects 4, 8 and 16 active lanes. Every bit of `dst` at or above the active width is 0.
- R2: `vlen` code 3 is illegal. It is handled as 4 lanes, and `vlen_err` is 1 with that result. Otherwise `vlen_err` is 0.
- R3: An active lane holds the computed value when `mask_on` is 0 or when `wmask[j]` is 1.
- R4: An active lane whose mask disables it is 0 when `zero_mode` is 1. When `zero_mode` is 0 it equals lane j of `dst_prev`.
- R5: When `bcast` is 1, every lane uses `src_b[31:0]` as its second operand.
- R6: `ctrl[1:0]` selects the comparison: 00 signed minimum, 01 signed maximum, 10 minimum magnitude, 11 maximum magnitude. When the two operands have equal magnitude and opposite signs, zeros included, the maximum forms pick the positive operand and the minimum forms pick the negative one. The same `ctrl` applies to all lanes.
- R7: `ctrl[3:2]` sets the result sign: 00 takes the sign of operand A, 01 keeps the sign of the selected value, 10 clears it, 11 sets it.
- R8: A NaN is signalling when bit 22 is 0 and quiet when bit 22 is 1. If A is a signalling NaN, the result is A with bit 22 set and the lane raises invalid. Otherwise, if B is a signalling NaN, the result is B with bit 22 set and the lane raises invalid. In both cases `ctrl[3:2]` is ignored. Otherwise a quiet-NaN B selects A, and a quiet-NaN A selects B.
- R9: A denormal has exponent 0 and a nonzero fraction. With `daz` 1, a denormal operand's fraction is cleared, keeping its sign, before selection, and no denormal flag is raised. With `daz` 0, the lane raises denormal when A is denormal and B is not a quiet NaN, or when B is denormal and A is not a quiet NaN, except in the signalling-NaN cases of R8.
- R10: `flag_inv` and `flag_den` are the OR of the lane flags over active lanes whose mask enables them only.
- R11: `out_valid` follows `in_valid` by one cycle. `dst`, the flags and `vlen_err` update only on an input strobe and hold otherwise. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| src_a | input | 512 | First operand lanes |
| src_b | input | 512 | Second operand lanes |
| dst_prev | input | 512 | Previous destination, used for merging |
| wmask | input | 16 | Per-lane write mask |
| mask_on | input | 1 | 1 enables the write mask |
| zero_mode | input | 1 | 1 writes zero in masked lanes, 0 merges |
| bcast | input | 1 | 1 uses src_b[31:0] for every lane |
| ctrl | input | 4 | [1:0] comparison, [3:2] sign rule |
| daz | input | 1 | Treat denormal operands as zero |
| vlen | input | 2 | Active length code |
| out_valid | output | 1 | Result strobe |
| dst | output | 512 | Result lanes |
| flag_inv | output | 1 | Invalid flag, ORed over contributing lanes |
| flag_den | output | 1 | Denormal flag, ORed over contributing lanes |
| vlen_err | output | 1 | Illegal length code seen |

## Verification
Two functions can act on the same lane in the same cycle: mask suppression and exception raising. A lane can hold a signalling NaN or a denormal while its mask bit disables it, or while it lies above the active length. The bench provokes this with random operands drawn from a pool that is rich in NaNs and denormals, random masks and random length codes. A behavioural model judges each cycle's flags from the contributing lanes only, and one directed case sets only a masked NaN lane, where both flags must stay 0.

// File: rtl/fbound_pkg.sv
package fbound_pkg;
  localparam int FW = 32;

  typedef enum logic [1:0] {
    VL_Q = 2'd0,
    VL_H = 2'd1,
    VL_F = 2'd2,
    VL_X = 2'd3
  } vl_code_e;

  function automatic int unsigned lanes_for(input logic [1:0] code, input int unsigned full);
    case (code)
      VL_H:    lanes_for = full / 2;
      VL_F:    lanes_for = full;
      default: lanes_for = full / 4;
    endcase
  endfunction
endpackage

// File: rtl/fbound_lane.sv
module fbound_lane
  import fbound_pkg::*;
(
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  input  logic [1:0]    op,
  input  logic [1:0]    sgn,
  input  logic          daz,
  output logic [FW-1:0] res,
  output logic          inv,
  output logic          den
);
  logic a_nan, b_nan, a_sn, b_sn, a_qn, b_qn, a_dn, b_dn;
  logic [FW-1:0] af, bf, tmp, picked;
  logic mag_lt, mag_eq, sgn_lt, a_less, pick_a;

  always_comb begin
    a_nan = (&a[30:23]) && (|a[22:0]);
    b_nan = (&b[30:23]) && (|b[22:0]);
    a_sn  = a_nan && !a[22];
    b_sn  = b_nan && !b[22];
    a_qn  = a_nan && a[22];
    b_qn  = b_nan && b[22];
    a_dn  = (a[30:23] == 8'd0) && (|a[22:0]);
    b_dn  = (b[30:23] == 8'd0) && (|b[22:0]);
    af    = (daz && a_dn) ? {a[31], 31'd0} : a;
    bf    = (daz && b_dn) ? {b[31], 31'd0} : b;

    mag_lt = af[30:0] < bf[30:0];
    mag_eq = af[30:0] == bf[30:0];
    if (af[31] != bf[31]) sgn_lt = af[31];
    else if (!af[31])     sgn_lt = mag_lt;
    else                  sgn_lt = !mag_lt && !mag_eq;

    a_less = op[1] ? mag_lt : sgn_lt;
    if (mag_eq && (af[31] != bf[31])) pick_a = op[0] ? !af[31] : af[31];
    else                              pick_a = op[0] ? (!a_less && !mag_eq) : a_less;

    if (b_qn)      tmp = af;
    else if (a_qn) tmp = bf;
    else           tmp = pick_a ? af : bf;

    case (sgn)
      2'b00:   picked = {a[31], tmp[30:0]};
      2'b01:   picked = tmp;
      2'b10:   picked = {1'b0, tmp[30:0]};
      default: picked = {1'b1, tmp[30:0]};
    endcase

    inv = a_sn || b_sn;
    if (a_sn)      res = a | 32'h0040_0000;
    else if (b_sn) res = b | 32'h0040_0000;
    else           res = picked;

    den = !daz && !inv && ((a_dn && !b_qn) || (b_dn && !a_qn));
  end
endmodule

// File: rtl/fbound_merge.sv
module fbound_merge
  import fbound_pkg::*;
(
  input  logic          active,
  input  logic          enabled,
  input  logic          zero_mode,
  input  logic [FW-1:0] calc,
  input  logic [FW-1:0] prev,
  input  logic          inv_in,
  input  logic          den_in,
  output logic [FW-1:0] out,
  output logic          inv_out,
  output logic          den_out
);
  logic use_calc;
  always_comb begin
    use_calc = active && enabled;
    if (!active)       out = '0;
    else if (enabled)  out = calc;
    else if (zero_mode) out = '0;
    else               out = prev;
    inv_out = use_calc && inv_in;
    den_out = use_calc && den_in;
  end
endmodule

// File: rtl/fbound_vec_unit.sv
module fbound_vec_unit
  import fbound_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [LANES*32-1:0] src_a,
  input  logic [LANES*32-1:0] src_b,
  input  logic [LANES*32-1:0] dst_prev,
  input  logic [LANES-1:0]    wmask,
  input  logic                mask_on,
  input  logic                zero_mode,
  input  logic                bcast,
  input  logic [3:0]          ctrl,
  input  logic                daz,
  input  logic [1:0]          vlen,
  output logic                out_valid,
  output logic [LANES*32-1:0] dst,
  output logic                flag_inv,
  output logic                flag_den,
  output logic                vlen_err
);
  localparam int VW = LANES * FW;

  int unsigned      n_act;
  logic [VW-1:0]    dst_c;
  logic [LANES-1:0] inv_l, den_l;

  always_comb n_act = lanes_for(vlen, LANES);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [FW-1:0] b_op, calc;
    logic          inv_r, den_r;
    assign b_op = bcast ? src_b[FW-1:0] : src_b[j*FW +: FW];

    fbound_lane u_lane (
      .a   (src_a[j*FW +: FW]),
      .b   (b_op),
      .op  (ctrl[1:0]),
      .sgn (ctrl[3:2]),
      .daz (daz),
      .res (calc),
      .inv (inv_r),
      .den (den_r)
    );

    fbound_merge u_merge (
      .active    (j < n_act),
      .enabled   (!mask_on || wmask[j]),
      .zero_mode (zero_mode),
      .calc      (calc),
      .prev      (dst_prev[j*FW +: FW]),
      .inv_in    (inv_r),
      .den_in    (den_r),
      .out       (dst_c[j*FW +: FW]),
      .inv_out   (inv_l[j]),
      .den_out   (den_l[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst       <= '0;
      flag_inv  <= 1'b0;
      flag_den  <= 1'b0;
      vlen_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst      <= dst_c;
        flag_inv <= |inv_l;
        flag_den <= |den_l;
        vlen_err <= (vlen == VL_X);
      end
    end
  end
endmodule

// File: rtl/fbound_vec_chk.sv
module fbound_vec_chk #(
  parameter int LANES = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [LANES*32-1:0] dst_prev,
  input logic [LANES-1:0]    wmask,
  input logic                mask_on,
  input logic                zero_mode,
  input logic [1:0]          vlen,
  input logic                out_valid,
  input logic [LANES*32-1:0] dst,
  input logic                flag_inv,
  input logic                flag_den,
  input logic                vlen_err
);
  localparam int QW = LANES * 8;

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R11
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(dst)); // R11
  AST_ERR_CODE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (vlen_err == ($past(vlen) == 2'd3))); // R2
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && (vlen == 2'd0 || vlen == 2'd3) |=> dst[LANES*32-1:QW] == '0); // R1
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (rst)
    in_valid && mask_on && zero_mode && !wmask[0] |=> dst[31:0] == 32'd0); // R4
  AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (rst)
    in_valid && mask_on && !zero_mode && !wmask[0] |=> dst[31:0] == $past(dst_prev[31:0])); // R4
  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (rst)
    in_valid && mask_on && (wmask == '0) |=> !flag_inv && !flag_den); // R10
endmodule

bind fbound_vec_unit fbound_vec_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dst_prev(dst_prev), .wmask(wmask),
  .mask_on(mask_on), .zero_mode(zero_mode), .vlen(vlen), .out_valid(out_valid),
  .dst(dst), .flag_inv(flag_inv), .flag_den(flag_den), .vlen_err(vlen_err)
);

// File: tb/fbound_vec_unit_tb.sv
module fbound_vec_unit_tb_top;
  localparam int L = 16;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [L*32-1:0] src_a = '0, src_b = '0, dst_prev = '0, dst;
  logic [L-1:0] wmask = '0;
  logic mask_on = 0, zero_mode = 0, bcast = 0, daz = 0;
  logic [3:0] ctrl = '0;
  logic [1:0] vlen = '0;
  logic out_valid, flag_inv, flag_den, vlen_err;

  int checks = 0, fails = 0, cyc = 0;
  logic [L*32-1:0] m_dst = '0;
  logic m_ov = 0, m_inv = 0, m_den = 0, m_err = 0;

  always #10 clk = ~clk;

  fbound_vec_unit #(.LANES(L)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .dst_prev(dst_prev), .wmask(wmask), .mask_on(mask_on), .zero_mode(zero_mode),
    .bcast(bcast), .ctrl(ctrl), .daz(daz), .vlen(vlen), .out_valid(out_valid),
    .dst(dst), .flag_inv(flag_inv), .flag_den(flag_den), .vlen_err(vlen_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_nan(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction
  function automatic bit is_den(input logic [31:0] x);
    return x[30:23] == 0 && x[22:0] != 0;
  endfunction

  // behavioural lane model, R5..R9
  function automatic logic [31:0] lane_ref(input logic [31:0] a, input logic [31:0] b,
      input logic [3:0] c, input bit dz, output bit inv, output bit den);
    logic [31:0] t;
    longint ka, kb;
    bit aq, bq;
    inv = 0; den = 0;
    if (is_nan(a) && !a[22]) begin inv = 1; return a | 32'h0040_0000; end
    if (is_nan(b) && !b[22]) begin inv = 1; return b | 32'h0040_0000; end
    aq = is_nan(a); bq = is_nan(b);
    den = !dz && ((is_den(a) && !bq) || (is_den(b) && !aq));
    if (dz && is_den(a)) a = {a[31], 31'd0};
    if (dz && is_den(b)) b = {b[31], 31'd0};
    if (bq) t = a;
    else if (aq) t = b;
    else begin
      ka = longint'(a[30:0]); kb = longint'(b[30:0]);
      if (!c[1]) begin if (a[31]) ka = -ka; if (b[31]) kb = -kb; end
      if (ka == kb) begin
        if (a[31] == b[31]) t = a;
        else t = (c[0] ? !a[31] : a[31]) ? a : b;
      end else if (c[0]) t = (ka > kb) ? a : b;
      else t = (ka < kb) ? a : b;
    end
    case (c[3:2])
      2'b00: t[31] = a[31];
      2'b10: t[31] = 1'b0;
      2'b11: t[31] = 1'b1;
      default: ;
    endcase
    return t;
  endfunction

  task automatic model_step();
    int n;
    bit iv, dn;
    logic [31:0] r;
    m_ov = in_valid;
    if (!in_valid) return;
    n = (vlen == 1) ? 8 : (vlen == 2) ? 16 : 4;
    m_inv = 0; m_den = 0; m_err = (vlen == 3);
    for (int j = 0; j < L; j++) begin
      r = lane_ref(src_a[j*32 +: 32], bcast ? src_b[31:0] : src_b[j*32 +: 32], ctrl, daz, iv, dn);
      if (j >= n) m_dst[j*32 +: 32] = 0;
      else if (!mask_on || wmask[j]) begin
        m_dst[j*32 +: 32] = r; m_inv |= iv; m_den |= dn;
      end else m_dst[j*32 +: 32] = zero_mode ? 32'd0 : dst_prev[j*32 +: 32];
    end
  endtask

  function automatic string lane_req(input int j);
    int n = (vlen == 1) ? 8 : (vlen == 2) ? 16 : 4;
    if (j >= n) return "R1 lane above length";
    if (mask_on && !wmask[j]) return "R4 masked lane";
    return "R3/R6 computed lane";
  endfunction

  task automatic tick();
    model_step();
    @(posedge clk); #1;
    @(negedge clk);
    check("R11 out_valid", {31'd0, out_valid}, {31'd0, m_ov});
    for (int j = 0; j < L; j++) check(lane_req(j), dst[j*32 +: 32], m_dst[j*32 +: 32]);
    check("R10 flag_inv", {31'd0, flag_inv}, {31'd0, m_inv});
    check("R9/R10 flag_den", {31'd0, flag_den}, {31'd0, m_den});
    check("R2 vlen_err", {31'd0, vlen_err}, {31'd0, m_err});
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 13))
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h4316_0000;  3: return 32'hC316_0000;
      4: return 32'h0000_0005;  5: return 32'h8040_0001;
      6: return 32'h7FC0_1234;  7: return 32'hFF80_0003;
      8: return 32'h7F80_0000;  9: return 32'hFF80_0000;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R11 reset valid", {31'd0, out_valid}, 32'd0);
    check("R11 reset dst", dst[31:0] | dst[L*32-1 -: 32], 32'd0);
    check("R11 reset flags", {29'd0, flag_inv, flag_den, vlen_err}, 32'd0);

    // R5 broadcast clamp: |x|<=150 with sign of A, min magnitude
    in_valid = 1; vlen = 2; mask_on = 0; bcast = 1; ctrl = 4'b0010; daz = 0;
    src_b = '0; src_b[31:0] = 32'h4316_0000;
    for (int j = 0; j < L; j++) src_a[j*32 +: 32] = 32'hC348_0000;
    tick();
    check("R5 broadcast lane15", dst[L*32-1 -: 32], 32'hC316_0000);

    // R7 sign set on max
    bcast = 0; vlen = 0; ctrl = 4'b1101;
    src_a[31:0] = 32'h3F80_0000; src_b[31:0] = 32'hC000_0000;
    tick();
    check("R7 sign forced", dst[31:0], 32'hBF80_0000);

    // R8 signalling NaN ignores sign rule
    ctrl = 4'b1001; src_a[31:0] = 32'h7F80_0001;
    tick();
    check("R8 quieted A", dst[31:0], 32'h7FC0_0001);
    check("R8 invalid", {31'd0, flag_inv}, 32'd1);

    // R9 denormal vs -0, max, keep selected sign
    ctrl = 4'b0101; src_a[31:0] = 32'h0000_0001; src_b[31:0] = 32'h8000_0000; daz = 1;
    tick();
    check("R9 daz flush to +0", dst[31:0], 32'h0000_0000);
    daz = 0;
    tick();
    check("R9 denormal kept", dst[31:0], 32'h0000_0001);
    check("R9 denormal flag", {31'd0, flag_den}, 32'd1);

    // R6 opposite equal magnitude, max magnitude picks positive
    ctrl = 4'b0111; src_a[31:0] = 32'hC316_0000; src_b[31:0] = 32'h4316_0000;
    tick();
    check("R6 equal magnitude max", dst[31:0], 32'h4316_0000);

    // R10 signalling NaN only in a masked lane
    ctrl = 4'b0000; src_a = '0; src_b = '0; src_a[63:32] = 32'h7F80_0001;
    mask_on = 1; wmask = 16'hFFFD; zero_mode = 1;
    tick();
    check("R10 masked NaN silent", {31'd0, flag_inv}, 32'd0);
    check("R4 zeroed lane1", dst[63:32], 32'd0);

    // R2 illegal length
    mask_on = 0; vlen = 3; src_a = '1; src_b = '1;
    tick();
    check("R2 error raised", {31'd0, vlen_err}, 32'd1);
    check("R2 lane4 zero", dst[159:128], 32'd0);

    // R11 hold while idle
    in_valid = 0;
    tick();

    // random sweep
    for (int k = 0; k < 1500; k++) begin
      in_valid = ($urandom_range(0, 7) != 0);
      for (int j = 0; j < L; j++) begin
        src_a[j*32 +: 32] = pick_val();
        src_b[j*32 +: 32] = pick_val();
        dst_prev[j*32 +: 32] = $urandom();
      end
      wmask = 16'($urandom()); mask_on = $urandom_range(0, 1) == 1;
      zero_mode = $urandom_range(0, 1) == 1; bcast = $urandom_range(0, 3) == 0;
      ctrl = 4'($urandom()); daz = $urandom_range(0, 1) == 1; vlen = 2'($urandom());
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule